// File: doc/BRIEF.md
# Integer Execute Unit

This block is the purely combinational execute unit of a 32-bit integer core. In the same cycle it picks its two operands from the register read values, the current program counter and a sign-extended immediate. It applies the arithmetic, logic, shift or comparison named by a 6-bit operation code and drives three results: a word-wide result, a branch-taken flag and a 16-bit jump-register target.

The operation code has two fields. Bits [5:3] name an operation class: base, alternate, branch compare or jump link. Bits [2:0] carry the instruction's three-bit function field unchanged. An upstream decoder builds the code, and the fetch logic uses the taken flag and the target. The unit holds no state, so every output is a function of the inputs presented in the same cycle.

Top module: `exu_top`

## Requirements
- R1: With code bits [5:3] = 000, bits [2:0] pick the base operation on operands A and B.
  - 000 is add, 001 is shift left logical, 010 is signed less-than (result 1 or 0), 011 is unsigned less-than, 100 is xor, 101 is shift right logical, 110 is or and 111 is and.
  - Shifts use only operand B bits [4:0] as the amount.
- R2: Code 001000 gives A minus B, and code 001101 gives A shifted right arithmetically by operand B bits [4:0]. Every other code with class 001 is unused.
- R3: With class 010 and branchOp high, branchTaken is 1 exactly when the selected comparison of A against B holds.
  - Function 000 compares for equal, 001 for not equal, 100 for signed less-than and 101 for signed greater-or-equal.
  - Function 110 compares for unsigned less-than and 111 for unsigned greater-or-equal.
  - Functions 010 and 011 are never taken. Class 010 codes give a result of 0.
- R4: branchTaken is 0 whenever branchOp is low, and whenever the code's class is not 010.
- R5: Codes 011111 and 111111 both pass operand A unchanged to the result.
- R6: aSel picks operand A. The value 0 picks rs1Val. The value 1 picks pc, zero-extended to 32 bits. The value 2 picks that zero-extended pc plus 4, added at full word width. The value 3 forces the result to 0 for every code.
- R7: bSel = 0 picks rs2Val as operand B, and bSel = 1 picks imm.
- R8: Every code not named in R1, R2 or R5 gives a result of 0.
- R9: jrTarget equals the low 16 bits of rs1Val plus the low 16 bits of imm, modulo 2^16, with bit 0 cleared. It does not depend on aSel, bSel or the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs1Val | input | 32 | first register read value |
| rs2Val | input | 32 | second register read value |
| pc | input | 16 | address of the current instruction |
| imm | input | 32 | sign-extended immediate |
| aSel | input | 2 | operand A source select |
| bSel | input | 1 | operand B source select |
| aluCtrl | input | 6 | operation code, class in [5:3] and function in [2:0] |
| branchOp | input | 1 | current instruction is a conditional branch |
| result | output | 32 | operation result |
| branchTaken | output | 1 | conditional branch resolves taken |
| jrTarget | output | 16 | jump-register target address |

## Verification
All three outputs depend only on the inputs of the same cycle, with no register between input and output. The bench therefore applies each stimulus just after a rising edge and compares result, branchTaken and jrTarget with its model at the next falling edge, half a period later, in that same cycle. The sweep runs every code against every operand source and branch flag, using boundary operands such as 0, -1, the largest positive value and the most negative value. A random phase follows, so every expected value is due in the cycle its stimulus is applied.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU, OP_XOR,
    OP_SRL, OP_SRA, OP_OR, OP_AND, OP_PASSA, OP_ZERO
  } aluOpE;

  typedef enum logic [2:0] {
    CMP_EQ, CMP_NE, CMP_LT, CMP_GE, CMP_LTU, CMP_GEU, CMP_NEVER
  } cmpOpE;

  typedef enum logic [1:0] {
    SRC_RS1 = 2'd0, SRC_PC = 2'd1, SRC_PC4 = 2'd2, SRC_NONE = 2'd3
  } aSrcE;

  typedef struct packed {
    aluOpE aluOp;
    cmpOpE cmpOp;
    logic  branchEn;
    aSrcE  aSrc;
    logic  bImm;
  } exuStrobes;

  localparam logic [2:0] CLS_BASE = 3'b000;
  localparam logic [2:0] CLS_ALT  = 3'b001;
  localparam logic [2:0] CLS_CMP  = 3'b010;
  localparam logic [5:0] CODE_LINK_A = 6'b011111;
  localparam logic [5:0] CODE_LINK_B = 6'b111111;

endpackage

// File: rtl/exu_ctrl.sv
module exu_ctrl
  import exu_pkg::*;
#(
  parameter int CTRL_W = 6
) (
  input  logic [CTRL_W-1:0] aluCtrl,
  input  logic [1:0]        aSel,
  input  logic              bSel,
  input  logic              branchOp,
  output exuStrobes         strobes
);
  localparam int FN_W = 3;

  logic [CTRL_W-FN_W-1:0] opClass;
  logic [FN_W-1:0]        fn;
  aluOpE                  decodedOp;
  cmpOpE                  decodedCmp;

  assign opClass = aluCtrl[CTRL_W-1:FN_W];
  assign fn      = aluCtrl[FN_W-1:0];

  always_comb begin
    decodedOp = OP_ZERO;
    if (aluCtrl == CODE_LINK_A || aluCtrl == CODE_LINK_B) begin
      decodedOp = OP_PASSA;
    end else if (opClass == CLS_BASE) begin
      case (fn)
        3'b000:  decodedOp = OP_ADD;
        3'b001:  decodedOp = OP_SLL;
        3'b010:  decodedOp = OP_SLT;
        3'b011:  decodedOp = OP_SLTU;
        3'b100:  decodedOp = OP_XOR;
        3'b101:  decodedOp = OP_SRL;
        3'b110:  decodedOp = OP_OR;
        default: decodedOp = OP_AND;
      endcase
    end else if (opClass == CLS_ALT) begin
      case (fn)
        3'b000:  decodedOp = OP_SUB;
        3'b101:  decodedOp = OP_SRA;
        default: decodedOp = OP_ZERO;
      endcase
    end
  end

  always_comb begin
    decodedCmp = CMP_NEVER;
    if (opClass == CLS_CMP) begin
      case (fn)
        3'b000:  decodedCmp = CMP_EQ;
        3'b001:  decodedCmp = CMP_NE;
        3'b100:  decodedCmp = CMP_LT;
        3'b101:  decodedCmp = CMP_GE;
        3'b110:  decodedCmp = CMP_LTU;
        3'b111:  decodedCmp = CMP_GEU;
        default: decodedCmp = CMP_NEVER;
      endcase
    end
  end

  always_comb begin
    strobes.aSrc     = aSrcE'(aSel);
    strobes.bImm     = bSel;
    strobes.cmpOp    = decodedCmp;
    strobes.branchEn = branchOp && (decodedCmp != CMP_NEVER);
    strobes.aluOp    = (aSrcE'(aSel) == SRC_NONE) ? OP_ZERO : decodedOp;
  end

endmodule

// File: rtl/exu_datapath.sv
module exu_datapath
  import exu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 16,
  parameter int PC_INC = 4
) (
  input  exuStrobes         strobes,
  input  logic [XLEN-1:0]   rs1Val,
  input  logic [XLEN-1:0]   rs2Val,
  input  logic [ADDR_W-1:0] pc,
  input  logic [XLEN-1:0]   imm,
  output logic [XLEN-1:0]   result,
  output logic              branchTaken,
  output logic [ADDR_W-1:0] jrTarget
);
  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0]   pcWide;
  logic [XLEN-1:0]   opA;
  logic [XLEN-1:0]   opB;
  logic [SHW-1:0]    shamt;
  logic [ADDR_W-1:0] jrSum;
  logic              isEq;
  logic              isLtS;
  logic              isLtU;
  logic              cmpTrue;

  generate
    if (ADDR_W < XLEN) begin : g_pcExt
      assign pcWide = {{(XLEN-ADDR_W){1'b0}}, pc};
    end else begin : g_pcFull
      assign pcWide = pc[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    case (strobes.aSrc)
      SRC_RS1: opA = rs1Val;
      SRC_PC:  opA = pcWide;
      SRC_PC4: opA = pcWide + XLEN'(PC_INC);
      default: opA = '0;
    endcase
  end

  assign opB   = strobes.bImm ? imm : rs2Val;
  assign shamt = opB[SHW-1:0];

  assign isEq  = (opA == opB);
  assign isLtS = ($signed(opA) < $signed(opB));
  assign isLtU = (opA < opB);

  always_comb begin
    case (strobes.aluOp)
      OP_ADD:   result = opA + opB;
      OP_SUB:   result = opA - opB;
      OP_SLL:   result = opA << shamt;
      OP_SLT:   result = {{(XLEN-1){1'b0}}, isLtS};
      OP_SLTU:  result = {{(XLEN-1){1'b0}}, isLtU};
      OP_XOR:   result = opA ^ opB;
      OP_SRL:   result = opA >> shamt;
      OP_SRA:   result = $unsigned($signed(opA) >>> shamt);
      OP_OR:    result = opA | opB;
      OP_AND:   result = opA & opB;
      OP_PASSA: result = opA;
      default:  result = '0;
    endcase
  end

  always_comb begin
    case (strobes.cmpOp)
      CMP_EQ:  cmpTrue = isEq;
      CMP_NE:  cmpTrue = !isEq;
      CMP_LT:  cmpTrue = isLtS;
      CMP_GE:  cmpTrue = !isLtS;
      CMP_LTU: cmpTrue = isLtU;
      CMP_GEU: cmpTrue = !isLtU;
      default: cmpTrue = 1'b0;
    endcase
  end

  assign branchTaken = strobes.branchEn && cmpTrue;

  assign jrSum    = rs1Val[ADDR_W-1:0] + imm[ADDR_W-1:0];
  assign jrTarget = {jrSum[ADDR_W-1:1], 1'b0};

endmodule

// File: rtl/exu_top.sv
module exu_top
  import exu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 16,
  parameter int CTRL_W = 6
) (
  input  logic [XLEN-1:0]   rs1Val,
  input  logic [XLEN-1:0]   rs2Val,
  input  logic [ADDR_W-1:0] pc,
  input  logic [XLEN-1:0]   imm,
  input  logic [1:0]        aSel,
  input  logic              bSel,
  input  logic [CTRL_W-1:0] aluCtrl,
  input  logic              branchOp,
  output logic [XLEN-1:0]   result,
  output logic              branchTaken,
  output logic [ADDR_W-1:0] jrTarget
);
  exuStrobes strobes;

  exu_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
    .aluCtrl  (aluCtrl),
    .aSel     (aSel),
    .bSel     (bSel),
    .branchOp (branchOp),
    .strobes  (strobes)
  );

  exu_datapath #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_dp (
    .strobes     (strobes),
    .rs1Val      (rs1Val),
    .rs2Val      (rs2Val),
    .pc          (pc),
    .imm         (imm),
    .result      (result),
    .branchTaken (branchTaken),
    .jrTarget    (jrTarget)
  );

endmodule

// File: rtl/exu_chk.sv
module exu_chk #(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 16,
  parameter int CTRL_W = 6
) (
  input logic [XLEN-1:0]   rs1Val,
  input logic [XLEN-1:0]   rs2Val,
  input logic [ADDR_W-1:0] pc,
  input logic [XLEN-1:0]   imm,
  input logic [1:0]        aSel,
  input logic              bSel,
  input logic [CTRL_W-1:0] aluCtrl,
  input logic              branchOp,
  input logic [XLEN-1:0]   result,
  input logic              branchTaken,
  input logic [ADDR_W-1:0] jrTarget
);
  logic known;
  assign known = !$isunknown({rs1Val, rs2Val, pc, imm, aSel, bSel, aluCtrl, branchOp});

  always_comb begin
    if (known) begin
      AST_SEL3_ZERO: assert (aSel != 2'd3 || result == '0)
        else $error("operand A select 3 gave nonzero result"); // R6
      AST_NOBR_NOTAKE: assert (branchOp || !branchTaken)
        else $error("taken without branch flag"); // R4
      AST_CLASS_NOTAKE: assert (aluCtrl[CTRL_W-1:3] == 3'b010 || !branchTaken)
        else $error("taken outside compare class"); // R4
      AST_JR_EVEN: assert (jrTarget[0] == 1'b0)
        else $error("jump target odd"); // R9
      AST_CMP_RESULT_ZERO: assert (aluCtrl[CTRL_W-1:3] != 3'b010 || result == '0)
        else $error("compare class wrote a result"); // R3
      AST_LINK_RS1: assert (!((aluCtrl == 6'b011111 || aluCtrl == 6'b111111) && aSel == 2'd0) || result == rs1Val)
        else $error("link did not pass rs1"); // R5
      AST_SUB_IMM: assert (!(aluCtrl == 6'b001000 && aSel == 2'd0 && bSel) || result == rs1Val - imm)
        else $error("subtract with immediate wrong"); // R2
      AST_ADD_RS2: assert (!(aluCtrl == 6'b000000 && aSel == 2'd0 && !bSel) || result == rs1Val + rs2Val)
        else $error("add with rs2 wrong"); // R7
      AST_PC_SRC: assert (!(aluCtrl == 6'b011111 && aSel == 2'd1) || result == {{(XLEN-ADDR_W){1'b0}}, pc})
        else $error("pc source wrong"); // R6
    end
  end
endmodule

bind exu_top exu_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (
  .rs1Val(rs1Val), .rs2Val(rs2Val), .pc(pc), .imm(imm), .aSel(aSel), .bSel(bSel),
  .aluCtrl(aluCtrl), .branchOp(branchOp), .result(result),
  .branchTaken(branchTaken), .jrTarget(jrTarget)
);

// File: tb/sim_exu_top.sv
module sim_exu_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] rs1Val, rs2Val, imm, result;
  logic [15:0] pc, jrTarget;
  logic [1:0]  aSel;
  logic        bSel, branchOp, branchTaken;
  logic [5:0]  aluCtrl;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  exu_top u0 (
    .rs1Val(rs1Val), .rs2Val(rs2Val), .pc(pc), .imm(imm), .aSel(aSel), .bSel(bSel),
    .aluCtrl(aluCtrl), .branchOp(branchOp), .result(result),
    .branchTaken(branchTaken), .jrTarget(jrTarget)
  );

  logic [31:0] pats [8];
  initial begin
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h7FFF_FFFF; pats[3] = 32'h8000_0000;
    pats[4] = 32'h0000_0001; pats[5] = 32'h0000_001F;
    pats[6] = 32'h0000_0023; pats[7] = 32'hA5A5_F00F;
  end

  function automatic logic [31:0] expResult(input logic [5:0] c, input logic [1:0] as,
      input logic bs, input logic [31:0] r1, input logic [31:0] r2, input logic [31:0] im,
      input logic [15:0] p);
    logic [31:0] a, b;
    int sh;
    if (as == 2'd3) return 32'd0;
    a = (as == 2'd0) ? r1 : (as == 2'd1) ? {16'd0, p} : {16'd0, p} + 32'd4;
    b = bs ? im : r2;
    sh = int'(b % 32);
    if (c == 6'b011111 || c == 6'b111111) return a;
    if (c == 6'b001000) return a - b;
    if (c == 6'b001101) return $unsigned($signed(a) >>> sh);
    if (c[5:3] != 3'b000) return 32'd0;
    case (c[2:0])
      3'd0: return a + b;
      3'd1: return a << sh;
      3'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'd3: return (a < b) ? 32'd1 : 32'd0;
      3'd4: return a ^ b;
      3'd5: return a >> sh;
      3'd6: return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic logic expTaken(input logic [5:0] c, input logic [1:0] as, input logic bs,
      input logic br, input logic [31:0] r1, input logic [31:0] r2, input logic [31:0] im,
      input logic [15:0] p);
    logic [31:0] a, b;
    if (!br || c[5:3] != 3'b010) return 1'b0;
    a = (as == 2'd0) ? r1 : (as == 2'd1) ? {16'd0, p} : (as == 2'd2) ? {16'd0, p} + 32'd4 : 32'd0;
    b = bs ? im : r2;
    case (c[2:0])
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) < $signed(b);
      3'd5: return $signed(a) >= $signed(b);
      3'd6: return a < b;
      3'd7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string resTag(input logic [5:0] c, input logic [1:0] as);
    if (as == 2'd3) return "R6";
    if (c == 6'b001000 || c == 6'b001101) return "R2";
    if (c == 6'b011111 || c == 6'b111111) return "R5";
    if (c[5:3] == 3'b000) return "R1";
    if (c[5:3] == 3'b010) return "R3";
    return "R8";
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (code %b aSel %0d bSel %0d)",
               tag, act, exp, aluCtrl, aSel, bSel);
    end
  endtask

  task automatic applyAndCheck(input logic [5:0] c, input logic [1:0] as, input logic bs,
      input logic br, input logic [31:0] r1, input logic [31:0] r2, input logic [31:0] im,
      input logic [15:0] p);
    @(posedge clk);
    aluCtrl = c; aSel = as; bSel = bs; branchOp = br;
    rs1Val = r1; rs2Val = r2; imm = im; pc = p;
    @(negedge clk);
    check32(resTag(c, as), result, expResult(c, as, bs, r1, r2, im, p));
    check32(br ? "R3" : "R4", {31'd0, branchTaken}, {31'd0, expTaken(c, as, bs, br, r1, r2, im, p)});
    check32("R9", {16'd0, jrTarget}, {16'd0, (r1[15:0] + im[15:0]) & 16'hFFFE});
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    rs1Val = '0; rs2Val = '0; imm = '0; pc = '0;
    aSel = '0; bSel = 1'b0; aluCtrl = '0; branchOp = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check32("R1 reset", result, 32'd0);
    check32("R4 reset", {31'd0, branchTaken}, 32'd0);
    check32("R9 reset", {16'd0, jrTarget}, 32'd0);
    rstN = 1'b1;

    // R7: same add with each operand B source
    applyAndCheck(6'b000000, 2'd0, 1'b0, 1'b0, 32'd10, 32'd5, 32'd100, 16'h0);
    check32("R7 rs2", result, 32'd15);
    applyAndCheck(6'b000000, 2'd0, 1'b1, 1'b0, 32'd10, 32'd5, 32'd100, 16'h0);
    check32("R7 imm", result, 32'd110);
    // R6: pc plus 4 carries into bit 16
    applyAndCheck(6'b011111, 2'd2, 1'b0, 1'b0, 32'd0, 32'd0, 32'd0, 16'hFFFC);
    check32("R6 pc4", result, 32'h0001_0000);
    // R9: wrap at 16 bits, bit 0 cleared
    applyAndCheck(6'b111111, 2'd0, 1'b1, 1'b0, 32'h1234_FFFF, 32'd0, 32'h0000_0004, 16'h0);
    check32("R9 wrap", {16'd0, jrTarget}, 32'h0000_0002);

    for (int c = 0; c < 64; c++)
      for (int as = 0; as < 4; as++)
        for (int bs = 0; bs < 2; bs++)
          for (int br = 0; br < 2; br++)
            for (int i = 0; i < 8; i++)
              for (int j = 0; j < 8; j++)
                applyAndCheck(6'(c), 2'(as), 1'(bs), 1'(br), pats[i], pats[j],
                              pats[(j + 3) % 8], pats[i][15:0] ^ 16'h0F0C);

    for (int k = 0; k < 4000; k++)
      applyAndCheck(6'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                    $urandom, ($urandom % 3 == 0) ? $urandom % 64 : $urandom,
                    $urandom, 16'($urandom));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule